// File: doc/BRIEF.md
# Path Trace Message Buffer

This block holds a 16-byte trail trace message for each of several tributaries. A processor reaches every byte through one data register. The byte address is not supplied by the bus. It comes from a pointer inside the block that steps forward after every completed access. A single clear strobe returns that pointer to zero. The pointer is shared by all tributaries, so one clear is enough before loading several messages in turn.

Each tributary has its own ownership bit. While the bit is 1, the processor owns the buffer and may read or write it, and the transmit side sends zero bytes. When software clears the bit, the transmit sequencer takes over. It hands out the stored bytes one per multiframe strobe, starting at position 0 and wrapping after position 15. Software must place a CRC-7 byte, computed over the 15 identifier bytes, in position 0. The hardware sends every byte exactly as written and never checks it.

Top module: `path_trace_buf`

## Requirements
- R1: A write to the data register, completed while the selected tributary's ownership bit is 1, stores `bus_wdata` at the shared pointer's position in that tributary's 16-byte buffer.
- R2: A one-cycle `ptr_clr` pulse sets the shared pointer to position 0 on the next clock edge. It takes priority over an access that completes in the same cycle.
- R3: The pointer advances by exactly one when a strobe ends (`bus_stb` falls), for a read or a write, provided the ownership bit of the tributary addressed by that strobe is 1. A strobe held high for several cycles advances it only once.
- R4: After position 15 the pointer returns to 0. A read pass of 16 bytes can therefore follow a write pass of 16 bytes with no clear in between.
- R5: While the selected tributary's ownership bit is 1, `bus_rdata` shows the byte at the pointer's position in that tributary's buffer.
- R6: While the selected tributary's ownership bit is 0, `bus_rdata` is 0. Writes are ignored, and reads and writes leave the pointer unchanged.
- R7: While a tributary's ownership bit is 1, its transmit lane is 0 from the next cycle on, and its transmit position returns to 0.
- R8: While a tributary's ownership bit is 0, each `mf_stb` pulse of that tributary loads the byte at its transmit position into its lane, one cycle after the pulse. The first byte sent is position 0, and the position wraps from 15 to 0.
- R9: Every byte, including an arbitrary value in position 0, is transmitted exactly as stored, with no check of its contents.
- R10: Tributaries are independent. A write to one tributary's buffer never changes another's stored bytes or transmit lane. Lane t occupies bits [8t+7:8t] of `tx_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_clr | input | 1 | Pulse from the bus decode that clears the shared pointer |
| bus_stb | input | 1 | Data register access strobe; the access completes when it falls |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_sel | input | 2 | Tributary addressed by the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed tributary |
| cfg_access | input | 4 | Per-tributary ownership bit: 1 = processor, 0 = transmit |
| mf_stb | input | 4 | Per-tributary multiframe slot strobe |
| tx_byte | output | 32 | Transmit byte per tributary, lane t at bits [8t+7:8t] |

## Verification
The hardest case to reach from the ports is the shared pointer drifting out of step across tributaries. This can happen when an ignored access to a tributary that has given up ownership falls between accesses to a tributary that still owns its buffer, or when one strobe is held for several cycles. The stimulus interleaves such ignored and long accesses inside a partial load of another tributary. It then reads on without a clear, so any extra or missing pointer step shows up as a wrong byte. A bench-side model of the buffers and the pointer feeds a scoreboard queue. That queue also checks the transmit rotation across its wrap and its restart after ownership is taken back.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;

  // Next position of a circular pointer over 'depth' entries.
  function automatic int unsigned ring_next(input int unsigned pos, input int unsigned depth);
    return (pos + 1 >= depth) ? 0 : pos + 1;
  endfunction

  // Width of an index that selects one of 'n' items (at least 1 bit).
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ptb_bus_ptr.sv
module ptb_bus_ptr
  import ptb_pkg::*;
#(
  parameter int unsigned NUM_TRIB = 4,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned SEL_W   = idx_width(NUM_TRIB),
  localparam int unsigned PTR_W   = idx_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_clr,
  input  logic              bus_stb,
  input  logic              bus_wr,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NUM_TRIB-1:0] cfg_access,
  output logic [PTR_W-1:0]  ptr,
  output logic              acc_done,
  output logic              acc_ok,
  output logic              wr_fire,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [DATA_W-1:0] wr_data
);

  logic              stb_q;
  acc_kind_e         kind_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] wdata_q;

  // Capture the access attributes while the strobe is high; act on its trailing edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      kind_q  <= ACC_READ;
      sel_q   <= '0;
      wdata_q <= '0;
    end else begin
      stb_q <= bus_stb;
      if (bus_stb) begin
        kind_q  <= acc_kind_e'(bus_wr);
        sel_q   <= bus_sel;
        wdata_q <= bus_wdata;
      end
    end
  end

  assign acc_done = stb_q & ~bus_stb;
  assign acc_ok   = acc_done & cfg_access[sel_q];
  assign wr_fire  = acc_ok & (kind_q == ACC_WRITE);
  assign wr_sel   = sel_q;
  assign wr_data  = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr_clr) begin
      ptr <= '0;
    end else if (acc_ok) begin
      ptr <= PTR_W'(ring_next(int'(ptr), DEPTH));
    end
  end

endmodule

// File: rtl/ptb_store.sv
module ptb_store
  import ptb_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = idx_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0] bus_data,
  input  logic [PTR_W-1:0]  tx_addr,
  output logic [DATA_W-1:0] tx_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        mem[i] <= '0;
      end
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign bus_data = mem[bus_addr];
  assign tx_data  = mem[tx_addr];

endmodule

// File: rtl/ptb_tx_seq.sv
module ptb_tx_seq
  import ptb_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = idx_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              mf_stb,
  output logic [PTR_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] tx_byte
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr <= '0;
      tx_byte <= '0;
    end else if (hold) begin
      rd_addr <= '0;
      tx_byte <= '0;
    end else if (mf_stb) begin
      tx_byte <= rd_data;
      rd_addr <= PTR_W'(ring_next(int'(rd_addr), DEPTH));
    end
  end

endmodule

// File: rtl/path_trace_buf.sv
module path_trace_buf
  import ptb_pkg::*;
#(
  parameter int unsigned NUM_TRIB = 4,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned SEL_W   = idx_width(NUM_TRIB),
  localparam int unsigned PTR_W   = idx_width(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ptr_clr,
  input  logic                       bus_stb,
  input  logic                       bus_wr,
  input  logic [SEL_W-1:0]           bus_sel,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_TRIB-1:0]        cfg_access,
  input  logic [NUM_TRIB-1:0]        mf_stb,
  output logic [NUM_TRIB*DATA_W-1:0] tx_byte
);

  logic [PTR_W-1:0]  ptr;
  logic              acc_done;
  logic              acc_ok;
  logic              wr_fire;
  logic [SEL_W-1:0]  wr_sel;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] bus_rd  [NUM_TRIB];
  logic [DATA_W-1:0] tx_rd   [NUM_TRIB];
  logic [PTR_W-1:0]  tx_addr [NUM_TRIB];

  ptb_bus_ptr #(
    .NUM_TRIB (NUM_TRIB),
    .DEPTH    (DEPTH),
    .DATA_W   (DATA_W)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_clr    (ptr_clr),
    .bus_stb    (bus_stb),
    .bus_wr     (bus_wr),
    .bus_sel    (bus_sel),
    .bus_wdata  (bus_wdata),
    .cfg_access (cfg_access),
    .ptr        (ptr),
    .acc_done   (acc_done),
    .acc_ok     (acc_ok),
    .wr_fire    (wr_fire),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data)
  );

  for (genvar t = 0; t < int'(NUM_TRIB); t++) begin : g_trib
    logic trib_wr;
    assign trib_wr = wr_fire && (wr_sel == SEL_W'(t));

    ptb_store #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W)
    ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (trib_wr),
      .wr_addr  (ptr),
      .wr_data  (wr_data),
      .bus_addr (ptr),
      .bus_data (bus_rd[t]),
      .tx_addr  (tx_addr[t]),
      .tx_data  (tx_rd[t])
    );

    ptb_tx_seq #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W)
    ) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (cfg_access[t]),
      .mf_stb  (mf_stb[t]),
      .rd_addr (tx_addr[t]),
      .rd_data (tx_rd[t]),
      .tx_byte (tx_byte[t*DATA_W +: DATA_W])
    );
  end

  assign bus_rdata = cfg_access[bus_sel] ? bus_rd[bus_sel] : '0;

endmodule

// File: rtl/ptb_checker.sv
module ptb_checker
  import ptb_pkg::*;
#(
  parameter int unsigned NUM_TRIB = 4,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned SEL_W   = idx_width(NUM_TRIB),
  localparam int unsigned PTR_W   = idx_width(DEPTH)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ptr_clr,
  input logic                       bus_stb,
  input logic [SEL_W-1:0]           bus_sel,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [NUM_TRIB-1:0]        cfg_access,
  input logic [NUM_TRIB*DATA_W-1:0] tx_byte,
  input logic [PTR_W-1:0]           ptr,
  input logic                       acc_ok
);

  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (ptr == '0));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !ptr_clr && (ptr != PTR_W'(DEPTH - 1))) |=> (ptr == $past(ptr) + 1'b1));

  a_r3_held_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && !ptr_clr) |=> $stable(ptr));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !ptr_clr && (ptr == PTR_W'(DEPTH - 1))) |=> (ptr == '0));

  a_r6_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_ok && !ptr_clr) |=> $stable(ptr));

  a_r6_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_access[bus_sel] |-> (bus_rdata == '0));

  for (genvar t = 0; t < int'(NUM_TRIB); t++) begin : g_lane
    a_r7_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_access[t] |=> (tx_byte[t*DATA_W +: DATA_W] == '0));
  end

endmodule

bind path_trace_buf ptb_checker #(
  .NUM_TRIB (NUM_TRIB),
  .DEPTH    (DEPTH),
  .DATA_W   (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ptr_clr    (ptr_clr),
  .bus_stb    (bus_stb),
  .bus_sel    (bus_sel),
  .bus_rdata  (bus_rdata),
  .cfg_access (cfg_access),
  .tx_byte    (tx_byte),
  .ptr        (ptr),
  .acc_ok     (acc_ok)
);

// File: tb/path_trace_buf_test.sv
module path_trace_buf_test;

  localparam int NT = 4;
  localparam int DP = 16;
  localparam int DW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ptr_clr = 1'b0;
  logic            bus_stb = 1'b0;
  logic            bus_wr = 1'b0;
  logic [1:0]      bus_sel = '0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic [NT-1:0]   cfg_access = '0;
  logic [NT-1:0]   mf_stb = '0;
  logic [NT*DW-1:0] tx_byte;

  always #4 clk = ~clk;  // 125 MHz

  path_trace_buf uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_clr    (ptr_clr),
    .bus_stb    (bus_stb),
    .bus_wr     (bus_wr),
    .bus_sel    (bus_sel),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cfg_access (cfg_access),
    .mf_stb     (mf_stb),
    .tx_byte    (tx_byte)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] model [NT][DP];
  int mptr = 0;
  int txp [NT];
  int        q_t [$];
  logic [DW-1:0] q_b [$];
  string     q_r [$];

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic clr_ptr();
    @(negedge clk); ptr_clr = 1'b1;
    @(negedge clk); ptr_clr = 1'b0;
    mptr = 0;
  endtask

  task automatic set_access(input int t, input logic v);
    @(negedge clk); cfg_access[t] = v;
    if (v) txp[t] = 0;
  endtask

  task automatic bus_write(input int t, input logic [DW-1:0] d, input int hold);
    @(negedge clk);
    bus_sel = 2'(t); bus_wr = 1'b1; bus_wdata = d; bus_stb = 1'b1;
    repeat (hold) @(negedge clk);
    bus_stb = 1'b0;
    @(posedge clk);
    if (cfg_access[t]) begin
      model[t][mptr] = d;
      mptr = (mptr + 1) % DP;
    end
  endtask

  task automatic bus_read(input int t, input string req);
    logic [DW-1:0] exp;
    @(negedge clk);
    bus_sel = 2'(t); bus_wr = 1'b0; bus_stb = 1'b1;
    @(posedge clk); #2;
    exp = cfg_access[t] ? model[t][mptr] : '0;
    check(req, bus_rdata, exp);
    @(negedge clk); bus_stb = 1'b0;
    @(posedge clk);
    if (cfg_access[t]) mptr = (mptr + 1) % DP;
  endtask

  // Driver: pushes the expected lane value and pulses the strobe.
  task automatic tx_step(input int t, input string req);
    @(negedge clk);
    mf_stb[t] = 1'b1;
    q_t.push_back(t);
    q_r.push_back(req);
    if (cfg_access[t]) begin
      q_b.push_back('0);
      txp[t] = 0;
    end else begin
      q_b.push_back(model[t][txp[t]]);
      txp[t] = (txp[t] + 1) % DP;
    end
    @(negedge clk);
    mf_stb[t] = 1'b0;
  endtask

  // Monitor: pops one expected item per strobe edge and compares the lane.
  initial begin
    forever begin
      @(posedge clk);
      if (mf_stb != '0) begin
        int t;
        #2;
        if (q_t.size() == 0) begin
          check("R8 unexpected strobe", 8'h00, 8'hFF);
        end else begin
          t = q_t.pop_front();
          check(q_r.pop_front(), tx_byte[t*DW +: DW], q_b.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int t = 0; t < NT; t++) begin
      txp[t] = 0;
      for (int i = 0; i < DP; i++) model[t][i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // Reset state: no ownership, so reads give 0 (R6) and lanes are idle (R7)
    check("R6 reset rdata", bus_rdata, 8'h00);
    for (int t = 0; t < NT; t++) check("R7 reset lane", tx_byte[t*DW +: DW], 8'h00);

    // Load tributary 0 with an arbitrary position-0 byte (R1, R9)
    set_access(0, 1'b1);
    set_access(1, 1'b1);
    clr_ptr();
    for (int i = 0; i < DP; i++) bus_write(0, (i == 0) ? 8'hA5 : DW'(8'h40 + i), 1);
    // No clear: read-back pass follows the write pass after the wrap (R4, R5)
    for (int i = 0; i < DP; i++) bus_read(0, "R4 R5 readback after wrap");

    // Long strobes count once (R3)
    clr_ptr();
    bus_write(1, 8'h11, 4);
    bus_write(1, 8'h22, 1);
    bus_read(1, "R3 long strobe");
    clr_ptr();
    bus_read(1, "R3 pos0 after long strobe");
    bus_read(1, "R3 pos1 after long strobe");

    // Fill tributary 1 fully and confirm tributary 0 untouched (R10)
    clr_ptr();
    for (int i = 0; i < DP; i++) bus_write(1, DW'(8'h3C ^ (i * 17)), 1);
    for (int i = 0; i < DP; i++) bus_read(0, "R10 other buffer unchanged");

    // Clear mid-stream (R2)
    bus_write(0, 8'h5A, 1);
    bus_write(0, 8'h6B, 1);
    clr_ptr();
    bus_read(0, "R2 clear returns to position 0");

    // Ignored accesses interleaved with an owned load (R6)
    clr_ptr();
    bus_write(0, 8'hC1, 1);
    bus_write(2, 8'h77, 1);
    bus_read(2, "R6 rdata zero without ownership");
    bus_write(0, 8'hC2, 1);
    bus_read(0, "R6 pointer unchanged by ignored access");
    set_access(2, 1'b1);
    clr_ptr();
    bus_read(2, "R6 ignored write not stored");
    set_access(2, 1'b0);

    // Transmit rotation on tributary 0 across the wrap (R8, R9)
    set_access(0, 1'b0);
    for (int i = 0; i < DP + 3; i++) tx_step(0, "R8 R9 transmit rotation");
    // Owned tributary 1 keeps its lane at zero even when strobed (R7)
    tx_step(1, "R7 owned lane stays zero");
    // Write to tributary 1 must not disturb lane 0 (R10)
    @(negedge clk); #1;
    begin
      logic [DW-1:0] lane0;
      lane0 = tx_byte[0 +: DW];
      bus_write(1, 8'hEE, 1);
      @(negedge clk); #1;
      check("R10 lane 0 unaffected by other write", tx_byte[0 +: DW], lane0);
    end
    // Release tributary 1 and send two bytes
    set_access(1, 1'b0);
    tx_step(1, "R8 second tributary starts at position 0");
    tx_step(1, "R8 second tributary next byte");

    // Take back ownership: lane drops to 0 next cycle, restart at 0 (R7)
    set_access(0, 1'b1);
    @(posedge clk); #2;
    check("R7 lane zero after ownership taken", tx_byte[0 +: DW], 8'h00);
    set_access(0, 1'b0);
    tx_step(0, "R7 restart from position 0");
    tx_step(0, "R7 restart second byte");

    repeat (3) @(negedge clk);
    n_chk++;
    if (q_t.size() != 0) begin
      n_fail++;
      $display("FAIL R8: actual %0d pending items expected 0", q_t.size());
    end
    finish_run();
  end

endmodule